// File: doc/BRIEF.md
# Bicubic Surface Table Interpolator

This block evaluates a smooth two-dimensional control surface between the points of a constant sample grid. A caller presents an unsigned fixed-point coordinate pair together with a valid strobe. Two clock edges later the block returns a signed fixed-point value, obtained by cubic convolution with the a = -0.5 kernel. A new coordinate pair may be accepted on every clock edge.

Each coordinate is split into a 1-based grid index and a 7-bit fraction. The 4x4 neighbourhood around the index is read from the grid as seen through a padded view. That view repeats the first row and column once before the grid, and repeats the last row and column twice after it. Four cubic passes along x, one per neighbourhood row, run side by side and are registered. A single cubic pass along y then combines the four row results into the registered output.

Top module: `bicubic_surface_interp`

## Requirements
- R1: Each coordinate has FRAC fractional bits (default 7) at its low end. The bits above them form the integer grid index, and 1.0 addresses the first grid sample.
- R2: A coordinate pair whose fractions are both zero, with indices xi in 1..GRID_X and yi in 1..GRID_Y, returns TABLE[yi-1][xi-1] exactly.
- R3: The neighbourhood is read from a padded view of the grid. Padded index 0 maps to the first sample, k in 1..N maps to sample k-1, and N+1 and N+2 map to the last sample. This applies to both axes.
- R4: Row results are computed for the four padded rows yi-1..yi+2. Each is the cubic convolution along x over the four padded columns xi-1..xi+2 at fraction t. Weighted by 2^(3F+1) with T = t*2^F, the tap weights are -T·2^2F + 2T²·2^F - T³, 2^(3F+1) - 5T²·2^F + 3T³, T·2^2F + 4T²·2^F - 3T³ and -T²·2^F + T³. Each result is rounded to F fractional bits by adding 2^(3F) and shifting right arithmetically by 3F+1.
- R5: The output is the same rounded cubic convolution applied along y to the four row results, using the y fraction.
- R6: A coordinate whose integer part is 0 is treated as exactly 1.0. A coordinate whose integer part exceeds the grid size N is treated as exactly N.0. Both rules apply per axis.
- R7: out_valid rises exactly two clock edges after an edge at which in_valid is sampled high, and is low otherwise. Back-to-back inputs yield back-to-back results.
- R8: During and right after reset, out_valid and out_value are 0.
- R9: out_value keeps its value on every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate pair is presented this cycle |
| x_coord | input | $clog2(GRID_X+1)+FRAC | Unsigned x coordinate, FRAC fractional bits |
| y_coord | input | $clog2(GRID_Y+1)+FRAC | Unsigned y coordinate, FRAC fractional bits |
| out_valid | output | 1 | Interpolated value is present |
| out_value | output | DW | Signed interpolated value, FRAC fractional bits |

## Verification
A fault in the padded-index mapping only shows for coordinates whose window reaches the grid border. The bench therefore places points at the top-left and at the bottom-right corners, as well as inside the grid. A wrong row result or a stale stage register corrupts the single output two edges after the offending input. Each streamed result is compared against a model of the same weights in the cycle it appears. Pipeline valid faults show as a missing or extra strobe at exactly that same cycle.

// File: rtl/bicubic_pkg.sv
package bicubic_pkg;

    localparam int TAPS = 4;

    // Maps an index of the padded grid view (one leading, two trailing
    // replicas) to the index of the stored sample it shows.
    function automatic int pad_to_store(input int k, input int n);
        if (k <= 0)
            return 0;
        else if (k > n)
            return n - 1;
        else
            return k - 1;
    endfunction

endpackage

// File: rtl/bicubic_coord_split.sv
module bicubic_coord_split #(
    parameter int GRID = 25,
    parameter int FRAC = 7,
    localparam int IW  = $clog2(GRID + 1),
    localparam int CW  = IW + FRAC
) (
    input  logic [CW-1:0]   coord,
    output logic [IW-1:0]   idx,
    output logic [FRAC-1:0] frac
);
    logic [IW-1:0] whole;

    always_comb begin
        whole = coord[CW-1:FRAC];
        if (whole == '0) begin
            idx  = IW'(1);
            frac = '0;
        end else if (whole > IW'(GRID)) begin
            idx  = IW'(GRID);
            frac = '0;
        end else begin
            idx  = whole;
            frac = coord[FRAC-1:0];
        end
    end
endmodule

// File: rtl/bicubic_window_rom.sv
module bicubic_window_rom
    import bicubic_pkg::*;
#(
    parameter int GRID_X = 25,
    parameter int GRID_Y = 25,
    parameter int DW     = 18,
    parameter logic signed [DW-1:0] TABLE [GRID_Y][GRID_X] = '{default: '0},
    localparam int XI_W  = $clog2(GRID_X + 1),
    localparam int YI_W  = $clog2(GRID_Y + 1),
    localparam int XA_W  = (GRID_X > 1) ? $clog2(GRID_X) : 1,
    localparam int YA_W  = (GRID_Y > 1) ? $clog2(GRID_Y) : 1
) (
    input  logic [XI_W-1:0]                  xi,
    input  logic [YI_W-1:0]                  yi,
    output logic [TAPS-1:0][TAPS-1:0][DW-1:0] win
);
    for (genvar r = 0; r < TAPS; r++) begin : g_row
        logic [YA_W-1:0] row_addr;
        assign row_addr = YA_W'(pad_to_store(int'(yi) + r - 1, GRID_Y));
        for (genvar c = 0; c < TAPS; c++) begin : g_col
            logic [XA_W-1:0] col_addr;
            assign col_addr   = XA_W'(pad_to_store(int'(xi) + c - 1, GRID_X));
            assign win[r][c]  = TABLE[row_addr][col_addr];
        end
    end
endmodule

// File: rtl/bicubic_cubic1d.sv
module bicubic_cubic1d #(
    parameter int DW   = 18,
    parameter int FRAC = 7,
    localparam int CW  = DW + 4,
    localparam int ACC = DW + 3 * FRAC + 6
) (
    input  logic signed [DW-1:0] f_m1,
    input  logic signed [DW-1:0] f_0,
    input  logic signed [DW-1:0] f_p1,
    input  logic signed [DW-1:0] f_p2,
    input  logic [FRAC-1:0]      t,
    output logic signed [DW-1:0] y
);
    logic signed [CW-1:0]  fm, f0, f1, f2, c1, c2, c3, dmid;
    logic [2*FRAC-1:0]     t_sq;
    logic [3*FRAC-1:0]     t_cu;
    logic signed [ACC-1:0] te, t2e, t3e, acc;

    assign fm = CW'(f_m1);
    assign f0 = CW'(f_0);
    assign f1 = CW'(f_p1);
    assign f2 = CW'(f_p2);

    // Polynomial coefficients built from shifts and adds only.
    assign dmid = f0 - f1;
    assign c1   = f1 - fm;
    assign c2   = (fm <<< 1) - ((f0 <<< 2) + f0) + (f1 <<< 2) - f2;
    assign c3   = (dmid <<< 1) + dmid + f2 - fm;

    assign t_sq = (2*FRAC)'(t) * (2*FRAC)'(t);
    assign t_cu = (3*FRAC)'(t_sq) * (3*FRAC)'(t);

    assign te  = ACC'($signed({1'b0, t}));
    assign t2e = ACC'($signed({1'b0, t_sq}));
    assign t3e = ACC'($signed({1'b0, t_cu}));

    assign acc = (ACC'(f0) <<< (3*FRAC + 1))
               + ((ACC'(c1) * te) <<< (2*FRAC))
               + ((ACC'(c2) * t2e) <<< FRAC)
               + (ACC'(c3) * t3e)
               + (ACC'(1) <<< (3*FRAC));

    assign y = DW'(acc >>> (3*FRAC + 1));
endmodule

// File: rtl/bicubic_surface_interp.sv
module bicubic_surface_interp
    import bicubic_pkg::*;
#(
    parameter int GRID_X = 25,
    parameter int GRID_Y = 25,
    parameter int FRAC   = 7,
    parameter int DW     = 18,
    parameter logic signed [DW-1:0] TABLE [GRID_Y][GRID_X] = '{default: '0},
    localparam int XI_W  = $clog2(GRID_X + 1),
    localparam int YI_W  = $clog2(GRID_Y + 1),
    localparam int XC_W  = XI_W + FRAC,
    localparam int YC_W  = YI_W + FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [XC_W-1:0]      x_coord,
    input  logic [YC_W-1:0]      y_coord,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_value
);
    typedef struct packed {
        logic                       s1_v;
        logic [FRAC-1:0]            s1_ty;
        logic [TAPS-1:0][DW-1:0]    s1_b;
        logic                       s2_v;
        logic [DW-1:0]              s2_y;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [XI_W-1:0]                    xi;
    logic [YI_W-1:0]                    yi;
    logic [FRAC-1:0]                    fx, fy;
    logic [TAPS-1:0][TAPS-1:0][DW-1:0]  win;
    logic [TAPS-1:0][DW-1:0]            row_res;
    logic signed [DW-1:0]               col_res;

    bicubic_coord_split #(.GRID(GRID_X), .FRAC(FRAC)) u_split_x (
        .coord(x_coord), .idx(xi), .frac(fx)
    );

    bicubic_coord_split #(.GRID(GRID_Y), .FRAC(FRAC)) u_split_y (
        .coord(y_coord), .idx(yi), .frac(fy)
    );

    bicubic_window_rom #(
        .GRID_X(GRID_X), .GRID_Y(GRID_Y), .DW(DW), .TABLE(TABLE)
    ) u_rom (
        .xi(xi), .yi(yi), .win(win)
    );

    for (genvar r = 0; r < TAPS; r++) begin : g_rows
        bicubic_cubic1d #(.DW(DW), .FRAC(FRAC)) u_row (
            .f_m1(win[r][0]), .f_0(win[r][1]), .f_p1(win[r][2]), .f_p2(win[r][3]),
            .t(fx), .y(row_res[r])
        );
    end

    bicubic_cubic1d #(.DW(DW), .FRAC(FRAC)) u_col (
        .f_m1(st_q.s1_b[0]), .f_0(st_q.s1_b[1]),
        .f_p1(st_q.s1_b[2]), .f_p2(st_q.s1_b[3]),
        .t(st_q.s1_ty), .y(col_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = in_valid;
        if (in_valid) begin
            st_d.s1_ty = fy;
            st_d.s1_b  = row_res;
        end
        st_d.s2_v = st_q.s1_v;
        if (st_q.s1_v)
            st_d.s2_y = col_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.s2_v;
    assign out_value = $signed(st_q.s2_y);
endmodule

// File: rtl/bicubic_surface_interp_chk.sv
module bicubic_surface_interp_chk #(
    parameter int GRID_X = 25,
    parameter int GRID_Y = 25,
    parameter int FRAC   = 7,
    parameter int DW     = 18,
    parameter logic signed [DW-1:0] TABLE [GRID_Y][GRID_X] = '{default: '0},
    localparam int XI_W  = $clog2(GRID_X + 1),
    localparam int YI_W  = $clog2(GRID_Y + 1),
    localparam int XC_W  = XI_W + FRAC,
    localparam int YC_W  = YI_W + FRAC
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [XC_W-1:0]      x_coord,
    input logic [YC_W-1:0]      y_coord,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_value
);
    logic            v1, v2;
    logic [XC_W-1:0] x1, x2;
    logic [YC_W-1:0] y1, y2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            x1 <= '0;   x2 <= '0;
            y1 <= '0;   y2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            x1 <= x_coord;  x2 <= x1;
            y1 <= y_coord;  y2 <= y1;
        end
    end

    logic                 on_grid;
    logic signed [DW-1:0] grid_ref;
    int                   gx, gy;

    always_comb begin
        gx       = int'(x2[XC_W-1:FRAC]);
        gy       = int'(y2[YC_W-1:FRAC]);
        on_grid  = v2 && (x2[FRAC-1:0] == '0) && (y2[FRAC-1:0] == '0)
                && gx >= 1 && gx <= GRID_X && gy >= 1 && gy <= GRID_Y;
        grid_ref = '0;
        if (on_grid)
            grid_ref = TABLE[gy-1][gx-1];
    end

    assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> out_valid);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |-> !out_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_value));

    assert_grid_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        on_grid |-> out_value == grid_ref);
endmodule

bind bicubic_surface_interp bicubic_surface_interp_chk #(
    .GRID_X(GRID_X), .GRID_Y(GRID_Y), .FRAC(FRAC), .DW(DW), .TABLE(TABLE)
) u_chk (.*);

// File: tb/bicubic_surface_interp_tb.sv
module bicubic_surface_interp_tb;
    localparam int GX   = 4;
    localparam int GY   = 4;
    localparam int FR   = 7;
    localparam int DWB  = 13;
    localparam int CWB  = $clog2(GX + 1) + FR;
    localparam int NV   = 10;

    localparam logic signed [DWB-1:0] TB_TABLE [GY][GX] = '{
        '{   0,  128,  256,  -64 },
        '{ 300, -200,   50,  400 },
        '{-128,   64,  512,  100 },
        '{ 256, -300,    0,  128 }
    };

    // Stimulus: raw Q3.7 coordinates.
    localparam int VX [NV] = '{128, 320, 512, 608, 128, 400, 256, 192, 384, 129};
    localparam int VY [NV] = '{128, 416, 512, 192, 256, 368, 576, 192, 128, 639};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [CWB-1:0]        x_coord = '0;
    logic [CWB-1:0]        y_coord = '0;
    logic                  out_valid;
    logic signed [DWB-1:0] out_value;

    int checks = 0;
    int fails  = 0;
    longint ext [GY+3][GX+3];

    always #5 clk = ~clk;

    bicubic_surface_interp #(
        .GRID_X(GX), .GRID_Y(GY), .FRAC(FR), .DW(DWB), .TABLE(TB_TABLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_coord(x_coord), .y_coord(y_coord),
        .out_valid(out_valid), .out_value(out_value)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint conv(input longint a, input longint b, input longint c,
                                    input longint d, input longint t);
        longint wa, wb, wc, wd;
        wa = -(t <<< (2*FR)) + ((2*t*t) <<< FR) - t*t*t;
        wb = (longint'(1) <<< (3*FR+1)) - ((5*t*t) <<< FR) + 3*t*t*t;
        wc = (t <<< (2*FR)) + ((4*t*t) <<< FR) - 3*t*t*t;
        wd = -((t*t) <<< FR) + t*t*t;
        return (a*wa + b*wb + c*wc + d*wd + (longint'(1) <<< (3*FR))) >>> (3*FR+1);
    endfunction

    function automatic longint model(input int xr, input int yr);
        int     xi, yi, xf, yf;
        longint b [4];
        xi = xr >> FR; xf = xr % (1 << FR);
        yi = yr >> FR; yf = yr % (1 << FR);
        if (xi == 0) begin xi = 1; xf = 0; end
        else if (xi > GX) begin xi = GX; xf = 0; end
        if (yi == 0) begin yi = 1; yf = 0; end
        else if (yi > GY) begin yi = GY; yf = 0; end
        for (int r = 0; r < 4; r++)
            b[r] = conv(ext[yi-1+r][xi-1], ext[yi-1+r][xi], ext[yi-1+r][xi+1],
                        ext[yi-1+r][xi+2], longint'(xf));
        return conv(b[0], b[1], b[2], b[3], longint'(yf));
    endfunction

    task automatic single(input int xr, input int yr, output longint res);
        @(negedge clk);
        x_coord = CWB'(xr); y_coord = CWB'(yr); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        res = longint'(out_value);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint got, ref_v;
        // Padded view built by copying the core, then replicating edges.
        for (int r = 0; r < GY; r++)
            for (int c = 0; c < GX; c++)
                ext[r+1][c+1] = longint'(TB_TABLE[r][c]);
        for (int r = 1; r <= GY; r++) begin
            ext[r][0]    = ext[r][1];
            ext[r][GX+1] = ext[r][GX];
            ext[r][GX+2] = ext[r][GX];
        end
        for (int c = 0; c < GX + 3; c++) begin
            ext[0][c]    = ext[1][c];
            ext[GY+1][c] = ext[GY][c];
            ext[GY+2][c] = ext[GY][c];
        end

        repeat (3) @(negedge clk);
        check("R8 out_valid in reset", longint'(out_valid), 0);
        check("R8 out_value in reset", longint'(out_value), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", longint'(out_valid), 0);

        // Streamed vectors, one per cycle (R1 R3 R4 R5 R7).
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R7 streamed valid", longint'(out_valid), 1);
                check("R4 R5 streamed value", longint'(out_value), model(VX[k-2], VY[k-2]));
            end
            if (k < NV) begin
                x_coord = CWB'(VX[k]); y_coord = CWB'(VY[k]); in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 valid drops after stream", longint'(out_valid), 0);

        // R9: idle output holds the last result.
        repeat (3) @(negedge clk);
        check("R9 hold while idle", longint'(out_value), model(VX[NV-1], VY[NV-1]));

        // R2: exact grid points return stored samples.
        single(128, 128, got);
        check("R2 grid (1,1)", got, longint'(TB_TABLE[0][0]));
        single(512, 512, got);
        check("R2 grid (4,4)", got, longint'(TB_TABLE[3][3]));
        single(384, 256, got);
        check("R2 grid (3,2)", got, longint'(TB_TABLE[1][2]));

        // R3: windows touching leading and trailing replicas.
        single(129, 129, got);
        check("R3 leading pad", got, model(129, 129));
        single(575, 639, got);
        check("R3 trailing pad", got, model(575, 639));

        // R6: clamping of out-of-range integer parts.
        single(64, 288, got);
        single(128, 288, ref_v);
        check("R6 low clamp x", got, ref_v);
        single(768, 300, got);
        single(512, 300, ref_v);
        check("R6 high clamp x", got, ref_v);
        single(330, 1023, got);
        check("R6 high clamp y", got, model(330, 512));

        // R7: single-shot latency of exactly two edges.
        @(negedge clk);
        x_coord = CWB'(200); y_coord = CWB'(300); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 not yet valid", longint'(out_valid), 0);
        @(negedge clk);
        check("R7 valid after two edges", longint'(out_valid), 1);
        check("R5 single value", longint'(out_value), model(200, 300));
        @(negedge clk);
        check("R7 one-cycle strobe", longint'(out_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule